// File: doc/BRIEF.md
# Two-Class Interrupt Masking Controller

The controller collects five interrupt request sources and decides, each cycle, whether one of them is taken. The sources are a machine-check pin, a critical input, a watchdog request, a debug event and an external input. The machine-check pin is edge-captured into a pending latch. The other four are level requests. Debug events that cannot be served at once leave a sticky status bit.

Requests fall into two classes. The external input is the only noncritical source. Machine check, critical input, watchdog and debug are critical. Each class is gated by enable bits in a machine state word. When a request is taken, the block does four things:
- it emits a one-cycle take pulse with a vector code;
- it copies the pre-entry state word into the save register of that class;
- it clears the class's enable bits;
- it clears a set of common mode bits.

A return strobe for each class reloads the state word from the matching save register. Software can also write the state word, and can clear the debug status with a write-one-to-clear strobe.

The control is a two-state machine:
- `ST_RUN` arbitrates every cycle. The transition `T_TAKE` leaves `ST_RUN` when a request wins. It updates the state word and save register at that same edge.
- `ST_ENTRY` drives the take pulse. It does no arbitration. The transition `T_SETTLE` always returns it to `ST_RUN` after one cycle.

State word layout:
- bits 6..0: mode bits (wait, user, float enable, float exception 0 and 1, instruction translate, data translate)
- bit 7: noncritical enable
- bit 8: critical enable
- bit 9: debug enable
- bits above 9: kept untouched by entry

Top module: `trap_gate_ctrl`

## Requirements
- R1: Among requests eligible in the same cycle, the winner is chosen in the order machine check, critical input, watchdog, debug, external. Vector codes are 1 for machine check, 2 for critical input, 3 for watchdog, 4 for debug and 5 for external. `take_crit` is 1 for every code except 5.
- R2: The external input is taken only while state bit 7 is 1. Its entry clears bit 7.
- R3: The critical input and the watchdog are gated by state bit 8. Debug is gated by state bit 9. Any critical-class entry clears bits 7, 8 and 9.
- R4: Every entry clears state bits 6..0. Bits above 9 are kept.
- R5: A request present in a cycle of `ST_RUN` produces `take` high for exactly one cycle, starting after the next clock edge. `take_vec` and `take_crit` are valid while `take` is high. Only one take is reported per entry.
- R6: A rising edge on `mchk_pin` sets a pending latch. This latch is taken whatever bits 7, 8 and 9 hold, and taking it clears it. A pin held high does not cause a second take.
- R7: The level requests (external, critical input, watchdog) are not stored. One that drops before its enable is set is never taken.
- R8: A debug event that is not taken in its cycle sets `dbg_stat`. While `dbg_stat` is 1 and bit 9 is 1, debug is requested. Taking debug clears `dbg_stat`.
- R9: `dbg_clr_wr` together with `dbg_clr_data` = 1 clears `dbg_stat`. A debug event in the same cycle wins, and the bit stays 1.
- R10: On entry, the pre-entry state word is copied to `save_nc_q` for the noncritical class, or to `save_cr_q` for the critical class.
- R11: `ret_cr` loads the state word from `save_cr_q`, and `ret_nc` loads it from `save_nc_q`. If both are high, `ret_cr` wins. Either return beats a state write. An entry beats all three.
- R12: After reset the state word, both save registers and `dbg_stat` are 0, `take` is 0, and no machine check is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 1 | External input request, level |
| crit_req | input | 1 | Critical input request, level |
| wdog_req | input | 1 | Watchdog request, level |
| dbg_event | input | 1 | Debug event |
| mchk_pin | input | 1 | Machine-check pin, rising-edge captured |
| state_wr_en | input | 1 | Software write of the state word |
| state_wr_data | input | STATE_W | Data for the state word write |
| dbg_clr_wr | input | 1 | Write strobe for the debug status |
| dbg_clr_data | input | 1 | Write-one-to-clear data for the debug status |
| ret_nc | input | 1 | Return from a noncritical interrupt |
| ret_cr | input | 1 | Return from a critical interrupt |
| take | output | 1 | One-cycle take pulse |
| take_vec | output | 3 | Vector code of the taken request |
| take_crit | output | 1 | Taken request is of the critical class |
| state_q | output | STATE_W | Machine state word |
| save_nc_q | output | STATE_W | Noncritical save register |
| save_cr_q | output | STATE_W | Critical save register |
| dbg_stat | output | 1 | Sticky debug status |

## Verification
Wrong enable bits in the state word show up as a take that should not happen, or a missing take, one cycle after the request is seen in `ST_RUN`. The bench's expected-take queue reports such a fault at that pulse, or at the end of the run. A stale machine-check latch or debug status shows the same way, and `dbg_stat` can also be seen directly on the cycle after the event or the clear. A wrong save or restore path shows at `save_nc_q`, `save_cr_q` or `state_q` on the cycle after the entry or return edge.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int B_WAIT   = 0;
    localparam int B_USER   = 1;
    localparam int B_FPU    = 2;
    localparam int B_FPX0   = 3;
    localparam int B_FPX1   = 4;
    localparam int B_IXLAT  = 5;
    localparam int B_DXLAT  = 6;
    localparam int B_NC_EN  = 7;
    localparam int B_CR_EN  = 8;
    localparam int B_DB_EN  = 9;
    localparam int MIN_STATE_W = 10;

    localparam int NSRC = 5;
    localparam int SRC_MCHK = 0;
    localparam int SRC_CRIT = 1;
    localparam int SRC_WDOG = 2;
    localparam int SRC_DBG  = 3;
    localparam int SRC_EXT  = 4;

    typedef enum logic [2:0] {
        VEC_NONE = 3'd0,
        VEC_MCHK = 3'd1,
        VEC_CRIT = 3'd2,
        VEC_WDOG = 3'd3,
        VEC_DBG  = 3'd4,
        VEC_EXT  = 3'd5
    } trap_vec_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_ENTRY = 1'b1
    } trap_fsm_e;
endpackage

// File: rtl/trap_prio.sv
module trap_prio #(
    parameter int N = 5,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/trap_edge_latch.sv
module trap_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr,
    output logic pend
);
    logic pin_d;
    logic rise;

    assign rise = pin & ~pin_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_d <= 1'b0;
            pend  <= 1'b0;
        end else begin
            pin_d <= pin;
            pend  <= rise | (pend & ~clr);
        end
    end
endmodule

// File: rtl/trap_dbg_sticky.sv
module trap_dbg_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic event_in,
    input  logic taken,
    input  logic clr_wr,
    input  logic clr_data,
    output logic stat
);
    logic sw_clr;
    logic set_now;

    assign sw_clr  = clr_wr & clr_data;
    assign set_now = event_in & ~taken;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= 1'b0;
        end else begin
            stat <= set_now | (stat & ~sw_clr & ~taken);
        end
    end
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
    import trap_pkg::*;
#(
    parameter int STATE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               entry,
    input  logic               entry_crit,
    input  logic               wr_en,
    input  logic [STATE_W-1:0] wr_data,
    input  logic               ret_nc,
    input  logic               ret_cr,
    output logic [STATE_W-1:0] state_q,
    output logic [STATE_W-1:0] save_nc_q,
    output logic [STATE_W-1:0] save_cr_q
);
    logic [STATE_W-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        for (int b = B_WAIT; b <= B_DXLAT; b++) begin
            clr_mask[b] = 1'b1;
        end
        clr_mask[B_NC_EN] = 1'b1;
        if (entry_crit) begin
            clr_mask[B_CR_EN] = 1'b1;
            clr_mask[B_DB_EN] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= '0;
            save_nc_q <= '0;
            save_cr_q <= '0;
        end else if (entry) begin
            state_q <= state_q & ~clr_mask;
            if (entry_crit) begin
                save_cr_q <= state_q;
            end else begin
                save_nc_q <= state_q;
            end
        end else if (ret_cr) begin
            state_q <= save_cr_q;
        end else if (ret_nc) begin
            state_q <= save_nc_q;
        end else if (wr_en) begin
            state_q <= wr_data;
        end
    end
endmodule

// File: rtl/trap_gate_ctrl.sv
module trap_gate_ctrl
    import trap_pkg::*;
#(
    parameter int STATE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_req,
    input  logic               crit_req,
    input  logic               wdog_req,
    input  logic               dbg_event,
    input  logic               mchk_pin,
    input  logic               state_wr_en,
    input  logic [STATE_W-1:0] state_wr_data,
    input  logic               dbg_clr_wr,
    input  logic               dbg_clr_data,
    input  logic               ret_nc,
    input  logic               ret_cr,
    output logic               take,
    output logic [2:0]         take_vec,
    output logic               take_crit,
    output logic [STATE_W-1:0] state_q,
    output logic [STATE_W-1:0] save_nc_q,
    output logic [STATE_W-1:0] save_cr_q,
    output logic               dbg_stat
);
    localparam int IW = $clog2(NSRC);

    trap_fsm_e      fsm_q, fsm_d;
    logic [NSRC-1:0] req;
    logic           any;
    logic [IW-1:0]  idx;
    logic           arb_ok;
    logic           entry;
    logic           entry_crit;
    logic           mchk_pend;
    logic           dbg_taken;
    logic [2:0]     vec_q;
    logic           crit_q;

    // Request vector in priority order (index 0 highest)
    assign req[SRC_MCHK] = mchk_pend;
    assign req[SRC_CRIT] = crit_req & state_q[B_CR_EN];
    assign req[SRC_WDOG] = wdog_req & state_q[B_CR_EN];
    assign req[SRC_DBG]  = (dbg_event | dbg_stat) & state_q[B_DB_EN];
    assign req[SRC_EXT]  = ext_req & state_q[B_NC_EN];

    trap_prio #(.N(NSRC)) u_prio (
        .req (req),
        .any (any),
        .idx (idx)
    );

    assign arb_ok     = (fsm_q == ST_RUN);
    assign entry      = arb_ok & any;
    assign entry_crit = (idx != IW'(SRC_EXT));
    assign dbg_taken  = entry & (idx == IW'(SRC_DBG));

    trap_edge_latch u_mchk (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (mchk_pin),
        .clr   (entry & (idx == IW'(SRC_MCHK))),
        .pend  (mchk_pend)
    );

    trap_dbg_sticky u_dbg (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_in (dbg_event),
        .taken    (dbg_taken),
        .clr_wr   (dbg_clr_wr),
        .clr_data (dbg_clr_data),
        .stat     (dbg_stat)
    );

    trap_state_regs #(.STATE_W(STATE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .entry      (entry),
        .entry_crit (entry_crit),
        .wr_en      (state_wr_en),
        .wr_data    (state_wr_data),
        .ret_nc     (ret_nc),
        .ret_cr     (ret_cr),
        .state_q    (state_q),
        .save_nc_q  (save_nc_q),
        .save_cr_q  (save_cr_q)
    );

    // Next state: T_TAKE (ST_RUN -> ST_ENTRY), T_SETTLE (ST_ENTRY -> ST_RUN)
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_RUN:   fsm_d = any ? ST_ENTRY : ST_RUN;
            ST_ENTRY: fsm_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q  <= ST_RUN;
            vec_q  <= VEC_NONE;
            crit_q <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
            if (entry) begin
                vec_q  <= 3'(idx) + 3'd1;
                crit_q <= entry_crit;
            end
        end
    end

    always_comb begin
        take      = (fsm_q == ST_ENTRY);
        take_vec  = vec_q;
        take_crit = crit_q;
    end
endmodule

// File: rtl/trap_gate_ctrl_chk.sv
module trap_gate_ctrl_chk
    import trap_pkg::*;
#(
    parameter int STATE_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ext_req,
    input logic               dbg_event,
    input logic               take,
    input logic [2:0]         take_vec,
    input logic               take_crit,
    input logic [STATE_W-1:0] state_q,
    input logic [STATE_W-1:0] save_nc_q,
    input logic [STATE_W-1:0] save_cr_q,
    input logic               dbg_stat
);
    p_take_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

    p_common_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (state_q[B_DXLAT:B_WAIT] == '0));

    p_nc_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !take_crit) |-> (!state_q[B_NC_EN] && $past(state_q[B_NC_EN]) && $past(ext_req)));

    p_cr_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_crit) |-> (state_q[B_DB_EN:B_NC_EN] == 3'b000));

    p_cr_save_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_crit) |-> (save_cr_q == $past(state_q)));

    p_nc_save_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !take_crit) |-> (save_nc_q == $past(state_q)));

    p_dbg_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_event && !state_q[B_DB_EN]) |=> dbg_stat);

    p_dbg_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_vec == VEC_DBG) |-> $past(state_q[B_DB_EN]));

    p_vec_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (take_vec != VEC_NONE && take_crit == (take_vec != VEC_EXT)));
endmodule

bind trap_gate_ctrl trap_gate_ctrl_chk #(.STATE_W(STATE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_req   (ext_req),
    .dbg_event (dbg_event),
    .take      (take),
    .take_vec  (take_vec),
    .take_crit (take_crit),
    .state_q   (state_q),
    .save_nc_q (save_nc_q),
    .save_cr_q (save_cr_q),
    .dbg_stat  (dbg_stat)
);

// File: tb/trap_gate_ctrl_tb.sv
module trap_gate_ctrl_tb;
    localparam int W = 16;
    localparam logic [2:0] V_MCHK = 3'd1, V_CRIT = 3'd2, V_WDOG = 3'd3, V_DBG = 3'd4, V_EXT = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_req = 0, crit_req = 0, wdog_req = 0, dbg_event = 0, mchk_pin = 0;
    logic state_wr_en = 0;
    logic [W-1:0] state_wr_data = '0;
    logic dbg_clr_wr = 0, dbg_clr_data = 0, ret_nc = 0, ret_cr = 0;
    logic take, take_crit, dbg_stat;
    logic [2:0] take_vec;
    logic [W-1:0] state_q, save_nc_q, save_cr_q;

    int n_chk = 0;
    int n_fail = 0;
    int n_takes = 0;
    logic [2:0] exp_q[$];

    always #4 clk = ~clk;

    trap_gate_ctrl #(.STATE_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .crit_req(crit_req),
        .wdog_req(wdog_req), .dbg_event(dbg_event), .mchk_pin(mchk_pin),
        .state_wr_en(state_wr_en), .state_wr_data(state_wr_data),
        .dbg_clr_wr(dbg_clr_wr), .dbg_clr_data(dbg_clr_data),
        .ret_nc(ret_nc), .ret_cr(ret_cr), .take(take), .take_vec(take_vec),
        .take_crit(take_crit), .state_q(state_q), .save_nc_q(save_nc_q),
        .save_cr_q(save_cr_q), .dbg_stat(dbg_stat)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input logic [2:0] v);
        exp_q.push_back(v);
    endtask

    task automatic wr_state(input logic [W-1:0] v);
        state_wr_en = 1'b1;
        state_wr_data = v;
        tick(1);
        state_wr_en = 1'b0;
    endtask

    task automatic pulse_ret(input logic cr);
        if (cr) ret_cr = 1'b1; else ret_nc = 1'b1;
        tick(1);
        ret_cr = 1'b0;
        ret_nc = 1'b0;
    endtask

    task automatic pulse_clr();
        dbg_clr_wr = 1'b1;
        dbg_clr_data = 1'b1;
        tick(1);
        dbg_clr_wr = 1'b0;
        dbg_clr_data = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Monitor: pop the expected take and compare vector and class (R1, R5)
    always @(negedge clk) begin
        if (rst_n && take) begin
            n_takes++;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R5 unexpected take actual_vec=%0d expected=none", take_vec);
            end else begin
                logic [2:0] e;
                e = exp_q.pop_front();
                if (take_vec !== e || take_crit !== (e != V_EXT)) begin
                    n_fail++;
                    $display("FAIL R1 take actual_vec=%0d crit=%0b expected_vec=%0d crit=%0b",
                             take_vec, take_crit, e, (e != V_EXT));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R5 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int t0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R12 reset state
        chk("R12 state", state_q, 0);
        chk("R12 save_nc", save_nc_q, 0);
        chk("R12 save_cr", save_cr_q, 0);
        chk("R12 dbg_stat", dbg_stat, 0);
        chk("R12 take", take, 0);

        // R2 R4 R10 external entry, R11 return
        wr_state(16'hA0FF);
        push_exp(V_EXT);
        ext_req = 1'b1;
        tick(3);
        chk("R2 R4 state after ext entry", state_q, 16'hA000);
        chk("R10 save_nc", save_nc_q, 16'hA0FF);
        ext_req = 1'b0;
        pulse_ret(1'b0);
        chk("R11 ret_nc restore", state_q, 16'hA0FF);
        tick(2);

        // R7 dropped level request is lost
        wr_state(16'h0000);
        t0 = n_takes;
        ext_req = 1'b1;
        tick(2);
        ext_req = 1'b0;
        tick(1);
        wr_state(16'h0080);
        tick(3);
        chk("R7 dropped ext not taken", n_takes, t0);

        // R1 R3 priority and critical entry
        wr_state(16'h03FF);
        push_exp(V_CRIT);
        crit_req = 1'b1; wdog_req = 1'b1; ext_req = 1'b1;
        tick(3);
        chk("R3 state after crit entry", state_q, 16'h0000);
        chk("R10 save_cr", save_cr_q, 16'h03FF);
        tick(2);
        crit_req = 1'b0;
        push_exp(V_WDOG);
        pulse_ret(1'b1);
        tick(3);
        chk("R11 ret_cr then wdog save_cr", save_cr_q, 16'h03FF);
        wdog_req = 1'b0;
        push_exp(V_EXT);
        pulse_ret(1'b1);
        tick(3);
        chk("R2 ext entry keeps bits 8 9", state_q, 16'h0300);
        chk("R10 save_nc after ext", save_nc_q, 16'h03FF);
        ext_req = 1'b0;
        pulse_ret(1'b0);
        chk("R11 ret_nc", state_q, 16'h03FF);

        // R1 R6 machine check beats critical input
        push_exp(V_MCHK);
        mchk_pin = 1'b1;
        tick(1);
        crit_req = 1'b1;
        tick(3);
        chk("R6 state after mchk", state_q, 16'h0000);
        chk("R6 save_cr after mchk", save_cr_q, 16'h03FF);
        tick(2);
        crit_req = 1'b0;
        t0 = n_takes;
        pulse_ret(1'b1);
        tick(3);
        chk("R6 held pin not retaken", n_takes, t0);
        mchk_pin = 1'b0;
        tick(1);

        // R6 machine check while all enables clear
        wr_state(16'h0000);
        t0 = n_takes;
        push_exp(V_MCHK);
        mchk_pin = 1'b1;
        tick(1);
        mchk_pin = 1'b0;
        tick(3);
        chk("R6 masked-state mchk taken", n_takes, t0 + 1);
        chk("R6 save_cr masked", save_cr_q, 16'h0000);

        // R8 masked debug fires later
        dbg_event = 1'b1;
        tick(1);
        dbg_event = 1'b0;
        chk("R8 dbg_stat set", dbg_stat, 1);
        t0 = n_takes;
        tick(3);
        chk("R8 no take while masked", n_takes, t0);
        push_exp(V_DBG);
        wr_state(16'h0200);
        tick(3);
        chk("R8 dbg_stat cleared by take", dbg_stat, 0);
        chk("R3 state after dbg", state_q, 16'h0000);
        chk("R10 save_cr dbg", save_cr_q, 16'h0200);

        // R9 write-one-to-clear and collision
        dbg_event = 1'b1;
        tick(1);
        dbg_event = 1'b0;
        pulse_clr();
        chk("R9 cleared", dbg_stat, 0);
        t0 = n_takes;
        wr_state(16'h0200);
        tick(3);
        chk("R9 cleared event never fires", n_takes, t0);
        wr_state(16'h0000);
        dbg_event = 1'b1;
        tick(1);
        dbg_clr_wr = 1'b1; dbg_clr_data = 1'b1;
        tick(1);
        dbg_event = 1'b0; dbg_clr_wr = 1'b0; dbg_clr_data = 1'b0;
        chk("R9 event wins over clear", dbg_stat, 1);
        pulse_clr();
        chk("R9 clear alone", dbg_stat, 0);

        // R11 return precedence
        ret_nc = 1'b1; ret_cr = 1'b1;
        tick(1);
        ret_nc = 1'b0; ret_cr = 1'b0;
        chk("R11 ret_cr wins", state_q, 16'h0200);
        state_wr_en = 1'b1; state_wr_data = 16'h1234; ret_nc = 1'b1;
        tick(1);
        state_wr_en = 1'b0; ret_nc = 1'b0;
        chk("R11 ret_nc beats write", state_q, 16'h03FF);
        tick(3);

        chk("R5 all expected takes seen", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule